// File: doc/BRIEF.md
# UART Interrupt Cause Arbiter

This block merges the four interrupt causes of a serial port into one interrupt request line and an identification byte. Software reads that byte to learn which cause to service. The four causes are, by group:

- a receiver line error;
- received data, or a character timeout;
- the transmit holding register becoming empty;
- a modem status change.

Each cause is enabled by its own bit of a 4-bit enable input. Each cause is also retired by its own register access, which the host reports to this block as one-cycle strobes.

Line errors, character timeouts and modem changes arrive as one-cycle event pulses and are held in sticky flags. Received-data availability is a level that the receiver keeps up for as long as its threshold is met. The transmit-empty cause is a sticky flag. It is armed by a rising edge of the holding-register empty level, or by its enable bit being switched on while the register is already empty.

A small state machine holds the reported cause and re-arbitrates on every clock. Its states are `C_NONE`, `C_LINE`, `C_RXTO`, `C_RXDATA`, `C_THRE` and `C_MODEM`. On each edge it moves to the highest-priority cause that is enabled and pending, or to `C_NONE` when no cause qualifies. Any state can move to any other in a single step. The irq line and the identification byte are decoded from this state.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, irq is 0 and ident equals 8'h01 while fifo_on is 0.
- R2: irq_en bit 0 enables received data and timeout, bit 1 enables transmit empty, bit 2 enables line error, and bit 3 enables modem change. A latched cause whose enable bit is 0 is not reported, but it stays latched and is reported once its bit is set.
- R3: ident[3:1] carries the cause code: 011 for line error, 010 for received data, 110 for character timeout, 001 for transmit empty, and 000 for modem change. ident[0] is 0 while a cause is reported and 1 otherwise.
- R4: The priority, highest first, is line error, then the receive group, then transmit empty, then modem change. Within the receive group a latched timeout is reported before the data level.
- R5: The line error flag is cleared by rd_lsr. The modem change flag is cleared by rd_msr.
- R6: The timeout flag is cleared by rd_rbr. The received-data cause follows the rx_avail level.
- R7: The transmit-empty flag sets when thr_empty rises while irq_en[1] is 1. It also sets when irq_en[1] rises while thr_empty is 1.
- R8: The transmit-empty flag is cleared by wr_thr. It is also cleared by rd_ident, but only while transmit empty is the reported cause.
- R9: irq equals the inverse of ident[0]. ident[5:4] are always 0. ident[7:6] read 11 when fifo_on is 1 and 00 when it is 0, following fifo_on without delay.
- R10: A source event or clear strobe shows on irq and ident at the second rising edge after it is sampled. An event and its clear strobe in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_en | input | 4 | Per-cause enable bits |
| line_err_evt | input | 1 | Pulse: receiver line error detected |
| rx_avail | input | 1 | Level: received data at or above threshold |
| rx_tmo_evt | input | 1 | Pulse: character timeout |
| thr_empty | input | 1 | Level: transmit holding register empty |
| modem_evt | input | 1 | Pulse: modem input changed |
| fifo_on | input | 1 | FIFOs enabled |
| rd_ident | input | 1 | Strobe: identification byte read |
| rd_lsr | input | 1 | Strobe: line status read |
| rd_rbr | input | 1 | Strobe: receive buffer read |
| rd_msr | input | 1 | Strobe: modem status read |
| wr_thr | input | 1 | Strobe: holding register written |
| irq | output | 1 | Interrupt request, active high |
| ident | output | 8 | Identification byte |

## Verification
On every cycle the assertions check the clear strobes for line, timeout and modem causes, the retirement of transmit empty by a write, and arming by an enable rise. They also check that a pending enabled line error always wins the next arbitration, and the fixed relation between irq and ident bits 0, 4 and 5.

The bench scenarios cover what needs a history to judge. These are the full priority order across all groups, and the rule that rd_ident retires transmit empty only while it is reported. They also include the reappearance of causes once enables return, the two-edge latency, and the rule that a set beats a clear arriving in the same cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        C_NONE,
        C_LINE,
        C_RXTO,
        C_RXDATA,
        C_THRE,
        C_MODEM
    } cause_e;

    localparam int EN_W      = 4;
    localparam int EN_RXDATA = 0;
    localparam int EN_THRE   = 1;
    localparam int EN_LINE   = 2;
    localparam int EN_MODEM  = 3;

    localparam int EVT_N     = 3;
    localparam int EVT_LINE  = 0;
    localparam int EVT_RXTO  = 1;
    localparam int EVT_MODEM = 2;

    localparam int CODE_W    = 3;
    localparam int ID_W      = 8;

    function automatic logic [CODE_W-1:0] cause_code(input cause_e c);
        logic [CODE_W-1:0] r;
        unique case (c)
            C_LINE:   r = 3'b011;
            C_RXDATA: r = 3'b010;
            C_RXTO:   r = 3'b110;
            C_THRE:   r = 3'b001;
            C_MODEM:  r = 3'b000;
            default:  r = 3'b000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    // one sticky flag per source; a set beats a clear in the same cycle
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
            else if (clr_i[i])
                q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_thre_detect.sv
module irq_thre_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic empty_i,
    input  logic wr_i,
    input  logic rd_clr_i,
    output logic flag_o
);
    logic empty_q;
    logic en_q;
    logic arm;

    // previous values for edge detection; empty_q starts high so an empty
    // register at reset gives no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            en_q    <= 1'b0;
        end else begin
            empty_q <= empty_i;
            en_q    <= en_i;
        end
    end

    assign arm = en_i & empty_i & (~empty_q | ~en_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (arm)
            flag_o <= 1'b1;
        else if (wr_i | rd_clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/irq_cause_fsm.sv
module irq_cause_fsm
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EN_W-1:0]   en_i,
    input  logic              line_i,
    input  logic              rxto_i,
    input  logic              rxdata_i,
    input  logic              thre_i,
    input  logic              modem_i,
    output cause_e            cause_o,
    output logic              irq_o,
    output logic [CODE_W-1:0] code_o
);
    cause_e state_q;
    cause_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= C_NONE;
        else
            state_q <= state_d;
    end

    // arbitration: every state may move to any cause in one step
    always_comb begin
        if (line_i && en_i[EN_LINE])
            state_d = C_LINE;
        else if (rxto_i && en_i[EN_RXDATA])
            state_d = C_RXTO;
        else if (rxdata_i && en_i[EN_RXDATA])
            state_d = C_RXDATA;
        else if (thre_i && en_i[EN_THRE])
            state_d = C_THRE;
        else if (modem_i && en_i[EN_MODEM])
            state_d = C_MODEM;
        else
            state_d = C_NONE;
    end

    // outputs
    always_comb begin
        cause_o = state_q;
        code_o  = cause_code(state_q);
        unique case (state_q)
            C_NONE:  irq_o = 1'b0;
            C_LINE, C_RXTO, C_RXDATA, C_THRE, C_MODEM: irq_o = 1'b1;
            default: irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  irq_en,
    input  logic        line_err_evt,
    input  logic        rx_avail,
    input  logic        rx_tmo_evt,
    input  logic        thr_empty,
    input  logic        modem_evt,
    input  logic        fifo_on,
    input  logic        rd_ident,
    input  logic        rd_lsr,
    input  logic        rd_rbr,
    input  logic        rd_msr,
    input  logic        wr_thr,
    output logic        irq,
    output logic [7:0]  ident
);
    logic [EVT_N-1:0]  evt_set;
    logic [EVT_N-1:0]  evt_clr;
    logic [EVT_N-1:0]  evt_q;
    logic              rx_q;
    logic              thre_q;
    logic              line_q;
    logic              to_q;
    logic              modem_q;
    cause_e            cause;
    logic [CODE_W-1:0] code;

    assign evt_set[EVT_LINE]  = line_err_evt;
    assign evt_clr[EVT_LINE]  = rd_lsr;
    assign evt_set[EVT_RXTO]  = rx_tmo_evt;
    assign evt_clr[EVT_RXTO]  = rd_rbr;
    assign evt_set[EVT_MODEM] = modem_evt;
    assign evt_clr[EVT_MODEM] = rd_msr;

    irq_evt_latch #(.N(EVT_N)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (evt_clr),
        .q_o   (evt_q)
    );

    assign line_q  = evt_q[EVT_LINE];
    assign to_q    = evt_q[EVT_RXTO];
    assign modem_q = evt_q[EVT_MODEM];

    // align the data level with the latched sources
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_q <= 1'b0;
        else
            rx_q <= rx_avail;
    end

    irq_thre_detect u_thre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (irq_en[EN_THRE]),
        .empty_i  (thr_empty),
        .wr_i     (wr_thr),
        .rd_clr_i (rd_ident && (cause == C_THRE)),
        .flag_o   (thre_q)
    );

    irq_cause_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (irq_en),
        .line_i   (line_q),
        .rxto_i   (to_q),
        .rxdata_i (rx_q),
        .thre_i   (thre_q),
        .modem_i  (modem_q),
        .cause_o  (cause),
        .irq_o    (irq),
        .code_o   (code)
    );

    assign ident = {{2{fifo_on}}, 2'b00, code, ~irq};
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] irq_en,
    input logic       line_err_evt,
    input logic       rx_tmo_evt,
    input logic       modem_evt,
    input logic       thr_empty,
    input logic       rd_lsr,
    input logic       rd_rbr,
    input logic       rd_msr,
    input logic       wr_thr,
    input logic       irq,
    input logic [7:0] ident,
    input logic       line_q,
    input logic       to_q,
    input logic       modem_q,
    input logic       thre_q
);
    a_r5_lsr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lsr && !line_err_evt |=> !line_q);

    a_r5_msr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_msr && !modem_evt |=> !modem_q);

    a_r6_rbr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rbr && !rx_tmo_evt |=> !to_q);

    a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_thr && !thr_empty |=> !thre_q);

    a_r7_enable_arms: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_en[1]) && thr_empty |=> thre_q);

    a_r4_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        line_q && irq_en[2] |=> irq && ident[3:1] == 3'b011);

    always @(negedge clk) begin
        if (rst_n) begin
            a_r9_irq_vs_bit0: assert (irq == !ident[0]);
            a_r9_reserved_zero: assert (ident[5:4] == 2'b00);
        end
    end
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_en       (irq_en),
    .line_err_evt (line_err_evt),
    .rx_tmo_evt   (rx_tmo_evt),
    .modem_evt    (modem_evt),
    .thr_empty    (thr_empty),
    .rd_lsr       (rd_lsr),
    .rd_rbr       (rd_rbr),
    .rd_msr       (rd_msr),
    .wr_thr       (wr_thr),
    .irq          (irq),
    .ident        (ident),
    .line_q       (line_q),
    .to_q         (to_q),
    .modem_q      (modem_q),
    .thre_q       (thre_q)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] irq_en = 4'h0;
    logic       line_err_evt = 1'b0;
    logic       rx_avail = 1'b0;
    logic       rx_tmo_evt = 1'b0;
    logic       thr_empty = 1'b0;
    logic       modem_evt = 1'b0;
    logic       fifo_on = 1'b0;
    logic       rd_ident = 1'b0;
    logic       rd_lsr = 1'b0;
    logic       rd_rbr = 1'b0;
    logic       rd_msr = 1'b0;
    logic       wr_thr = 1'b0;
    logic       irq;
    logic [7:0] ident;

    always #2.5 clk = ~clk;

    uart_irq_ident uut (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
        .line_err_evt(line_err_evt), .rx_avail(rx_avail),
        .rx_tmo_evt(rx_tmo_evt), .thr_empty(thr_empty),
        .modem_evt(modem_evt), .fifo_on(fifo_on), .rd_ident(rd_ident),
        .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr),
        .wr_thr(wr_thr), .irq(irq), .ident(ident)
    );

    typedef struct {
        int         due;
        logic [7:0] id;
        string      req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every expectation that has come due
    always @(negedge clk) begin : mon
        exp_t it;
        while (q.size() > 0 && q[0].due <= cyc) begin
            it = q.pop_front();
            n_cmp++;
            if (ident !== it.id || irq !== !it.id[0]) begin
                n_bad++;
                $display("FAIL %s: actual ident=%h irq=%b expected ident=%h irq=%b",
                         it.req, ident, irq, it.id, !it.id[0]);
            end
        end
    end

    task automatic expect_in(input int d, input logic [7:0] id, input string r);
        q.push_back('{cyc + d, id, r});
    endtask

    // called right after driving at a falling edge
    task automatic step(input logic [7:0] id, input string r);
        expect_in(2, id, r);
        @(negedge clk);
        line_err_evt = 0; rx_tmo_evt = 0; modem_evt = 0;
        rd_ident = 0; rd_lsr = 0; rd_rbr = 0; rd_msr = 0; wr_thr = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_in(0, 8'h01, "R1 reset state");
        @(negedge clk);

        @(negedge clk); line_err_evt = 1;      step(8'h01, "R2 disabled line not shown");
        @(negedge clk); irq_en = 4'b0100;      step(8'h06, "R2 latched line shown on enable");
        @(negedge clk); irq_en = 4'b1111; modem_evt = 1; step(8'h06, "R4 line over modem");
        @(negedge clk); rd_lsr = 1;            step(8'h00, "R5 lsr read exposes modem code");
        @(negedge clk); rd_msr = 1;            step(8'h01, "R5 msr read clears modem");

        @(negedge clk); rx_avail = 1;          step(8'h04, "R3 received data code");
        @(negedge clk); rx_tmo_evt = 1;        step(8'h0C, "R4 timeout before data");
        @(negedge clk); line_err_evt = 1;      step(8'h06, "R4 line over receive");
        @(negedge clk); rd_lsr = 1;            step(8'h0C, "R5 lsr read back to timeout");
        @(negedge clk); rd_rbr = 1;            step(8'h04, "R6 rbr read clears timeout");
        @(negedge clk); rx_avail = 0;          step(8'h01, "R6 data follows level");

        @(negedge clk); thr_empty = 1;         step(8'h02, "R7 empty edge arms");
        @(negedge clk); rd_ident = 1;          step(8'h01, "R8 ident read clears thre");
        @(negedge clk); irq_en = 4'b1101;      step(8'h01, "R2 thre disabled");
        @(negedge clk); irq_en = 4'b1111;      step(8'h02, "R7 enable rise arms");
        @(negedge clk); wr_thr = 1; thr_empty = 0; step(8'h01, "R8 write clears thre");

        @(negedge clk); thr_empty = 1;         step(8'h02, "R7 empty edge arms again");
        @(negedge clk); modem_evt = 1;         step(8'h02, "R4 thre over modem");
        @(negedge clk); rx_avail = 1;          step(8'h04, "R4 data over thre");
        @(negedge clk); rd_ident = 1;          step(8'h04, "R8 ident read while data shown");
        @(negedge clk); rx_avail = 0;          step(8'h02, "R8 thre kept by ident read");
        @(negedge clk); wr_thr = 1; thr_empty = 0; step(8'h00, "R8 write then modem shown");
        @(negedge clk); rd_msr = 1;            step(8'h01, "R5 msr read clears modem");

        @(negedge clk); fifo_on = 1;           step(8'hC1, "R9 fifo bits idle");
        @(negedge clk); line_err_evt = 1;      step(8'hC6, "R9 fifo bits with cause");
        @(negedge clk); rd_lsr = 1;            step(8'hC1, "R5 lsr clear with fifo on");

        @(negedge clk); line_err_evt = 1; rd_lsr = 1; step(8'hC6, "R10 set beats clear");
        @(negedge clk); rd_lsr = 1;            step(8'hC1, "R10 later clear works");

        @(negedge clk); line_err_evt = 1;
        expect_in(1, 8'hC1, "R10 not yet after one edge");
        step(8'hC6, "R10 shown after two edges");
        @(negedge clk); rd_lsr = 1;            step(8'hC1, "R5 lsr clear");

        @(negedge clk); irq_en = 4'b0111; modem_evt = 1; step(8'hC1, "R2 modem masked");
        @(negedge clk); irq_en = 4'b1111;      step(8'hC0, "R2 modem revealed");
        @(negedge clk); rd_msr = 1;            step(8'hC1, "R5 msr clear");

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R10 queue: actual=%0d pending expected=0", q.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule